// File: doc/BRIEF.md
# Vector Widening Operand Legality Checker

This block sits in the decode stage of a vector unit that has 32 architectural vector registers. For widening, quad-widening and integer-extension operations it looks at the destination and source register numbers and at the grouping factor. It also looks at the element width, the widest element the unit supports and the masking bit. From these it decides whether the register-group operands are legal. The decision is a single illegal-instruction flag.

The legality logic itself is combinational. The top module samples the operand fields on a valid strobe, so the verdict and a matching valid bit come out one clock later. A group of registers starts at a register number and covers a power-of-two count of registers. A fractional grouping counts as a group of size zero. Zero counts as aligned anywhere, and it counts as one register when overlap is tested.

Two overlap rules apply. The strict rule forbids any shared register between a source group and the destination group. The relaxed rule applies when the source group covers one or more whole registers. Under the relaxed rule, a narrower source may share registers with the destination only when the source occupies the topmost part of the destination group.

Top module: `vwid_legal_chk`

## Requirements
- R1: After a synchronous active-high reset, `res_valid` and `illegal` are 0. Whenever `in_valid` is high at a rising edge, `res_valid` is 1 after that edge and `illegal` carries the verdict for the sampled fields. When `in_valid` is low at an edge, `res_valid` is 0 after it and `illegal` keeps its previous value.
- R2: `lmul` is a signed log2 grouping code from -3 to +3. Code n gives a group of 2^n registers when n ≥ 0 and a group of size zero otherwise. Code 3'b100 (-4) is reserved and always illegal.
- R3: `op_class` selects the operation class: 0 double from single, 1 quad from single, 2 double from double and single, 3 extend by 2, 4 extend by 4, 5 extend by 8. Codes 6 and 7 are always illegal.
- R4: When `unmasked` is 0 (masking enabled) and `rd` is 0, the operation is illegal.
- R5: A register number must be a multiple of its group size. A zero-size (fractional) group is aligned at any register. Any misaligned operand that is checked makes the operation illegal.
- R6: Strict overlap applies when the source group size is zero, with both sizes taken as at least 1. Groups [a,a+A) and [b,b+B) conflict when max(a+A,b+B) − min(a,b) < A+B, and a conflict is illegal.
- R7: Relaxed overlap applies when the source group has one or more registers. A conflict is permitted when rd < source start and the destination does not meet a source-sized group that starts right after the source. All other conflicts are illegal.
- R8: Classes 0 and 2 require lmul ≤ 2 and 2·SEW ≤ ELEN. Here `sew` and `elen` are log2 codes in bytes (0=8 bits … 3=64 bits), and the destination group has size(lmul+1).
- R9: Class 1 requires lmul ≤ 1 and 4·SEW ≤ ELEN, and the destination group has size(lmul+2).
- R10: In class 2, rs2 must be aligned to size(lmul+1) and is not overlap-checked. In classes 0 and 1, rs2 has size(lmul) and is overlap-checked.
- R11: In classes 0, 1 and 2, rs1 is checked (size(lmul), aligned, overlap) only when `rs1_is_vec` is 1. Otherwise rs1 has no effect.
- R12: Extension by divisor 2^k (k = 1, 2, 3) uses destination size(lmul) and source size(lmul−k). It is illegal when the source element width is below 8 bits (`sew` < k). rs1 has no effect in these classes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for the operand fields |
| rd | input | 5 | Destination register number |
| rs1 | input | 5 | Source-1 register number |
| rs2 | input | 5 | Source-2 register number |
| lmul | input | 3 | Signed log2 grouping code |
| sew | input | 2 | Element width code, log2 bytes |
| elen | input | 2 | Maximum element width code, log2 bytes |
| op_class | input | 3 | Operation class selector |
| rs1_is_vec | input | 1 | Source 1 is a vector register |
| unmasked | input | 1 | 1 = unmasked, 0 = masked by register 0 |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| illegal | output | 1 | Illegal-operand verdict |

## Verification
Each verdict is due exactly one rising edge after the edge that samples `in_valid`, and it then holds until the next strobe. The bench drives new fields on a falling edge and reads `res_valid` and `illegal` on the following falling edge, so every reading lands midway between the capturing edge and the next one. Back-to-back strobes give one verdict per cycle. A hold check drops the strobe, changes every field, and confirms two falling edges later that the verdict has not moved.

// File: rtl/vwid_pkg.sv
package vwid_pkg;

    localparam int NUM_VREGS = 32;
    localparam int RIDX_W    = $clog2(NUM_VREGS);
    localparam int SZ_W      = RIDX_W + 3;   // holds start + 2 * largest group
    localparam int NUM_SRC   = 2;            // index 0: rs2, index 1: rs1

    typedef logic [RIDX_W-1:0] ridx_t;
    typedef logic [SZ_W-1:0]   gsz_t;
    typedef logic signed [3:0] l2_t;         // log2 group size, -7..+7

    typedef enum logic [2:0] {
        WID_DS = 3'd0,
        WID_QS = 3'd1,
        WID_DD = 3'd2,
        EXT_D2 = 3'd3,
        EXT_D4 = 3'd4,
        EXT_D8 = 3'd5
    } opclass_e;

    typedef struct packed {
        l2_t  dst_l2;
        l2_t  s2_l2;
        l2_t  s1_l2;
        logic s2_ovl_chk;
        logic s1_used;
        logic [1:0] ext_k;
    } geom_t;

    // Register count of a group; fractional groups give zero
    function automatic gsz_t grp_size(input l2_t l2);
        if (l2 < 4'sd0) return '0;
        return gsz_t'(1) << l2[2:0];
    endfunction

    function automatic logic grp_aligned(input ridx_t r, input gsz_t s);
        return (s == '0) || ((gsz_t'(r) & (s - gsz_t'(1))) == '0);
    endfunction

    function automatic gsz_t at_least_one(input gsz_t s);
        return (s == '0) ? gsz_t'(1) : s;
    endfunction

    function automatic logic spans_meet(input gsz_t a, input gsz_t an,
                                        input gsz_t b, input gsz_t bn);
        gsz_t ae;
        gsz_t be;
        gsz_t hi;
        gsz_t lo;
        ae = a + an;
        be = b + bn;
        hi = (ae > be) ? ae : be;
        lo = (a < b) ? a : b;
        return (hi - lo) < (an + bn);
    endfunction

    // Strict rule: any shared register conflicts
    function automatic logic clash_strict(input ridx_t d, input gsz_t dn,
                                          input ridx_t s, input gsz_t sn);
        return spans_meet(gsz_t'(d), at_least_one(dn), gsz_t'(s), at_least_one(sn));
    endfunction

    // Relaxed rule: a source in the top slice of the destination is allowed
    function automatic logic clash_relaxed(input ridx_t d, input gsz_t dn,
                                           input ridx_t s, input gsz_t sn);
        gsz_t dn1;
        gsz_t sn1;
        logic meet;
        logic meet_next;
        dn1       = at_least_one(dn);
        sn1       = at_least_one(sn);
        meet      = spans_meet(gsz_t'(d), dn1, gsz_t'(s), sn1);
        meet_next = spans_meet(gsz_t'(d), dn1, gsz_t'(s) + sn1, sn1);
        if ((d < s) && meet && !meet_next) return 1'b0;
        return meet;
    endfunction

endpackage

// File: rtl/vwid_geom.sv
module vwid_geom
    import vwid_pkg::*;
(
    input  logic [2:0] lmul,
    input  logic [2:0] op_class,
    input  logic       rs1_is_vec,
    output geom_t      geom
);
    l2_t base;

    always_comb begin
        base = {lmul[2], lmul};
        geom.dst_l2     = base + 4'sd1;
        geom.s2_l2      = base;
        geom.s1_l2      = base;
        geom.s2_ovl_chk = 1'b1;
        geom.s1_used    = rs1_is_vec;
        geom.ext_k      = 2'd0;
        case (op_class)
            WID_QS: geom.dst_l2 = base + 4'sd2;
            WID_DD: begin
                geom.s2_l2      = base + 4'sd1;
                geom.s2_ovl_chk = 1'b0;
            end
            EXT_D2, EXT_D4, EXT_D8: begin
                geom.ext_k   = (op_class == EXT_D2) ? 2'd1 :
                               (op_class == EXT_D4) ? 2'd2 : 2'd3;
                geom.dst_l2  = base;
                geom.s2_l2   = base - l2_t'({2'b00, geom.ext_k});
                geom.s1_used = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vwid_src_chk.sv
module vwid_src_chk
    import vwid_pkg::*;
(
    input  ridx_t rd,
    input  l2_t   dst_l2,
    input  ridx_t src,
    input  l2_t   src_l2,
    input  logic  used,
    input  logic  ovl_chk,
    output logic  bad
);
    gsz_t dsz;
    gsz_t ssz;
    logic misaligned;
    logic clash;

    always_comb begin
        dsz        = grp_size(dst_l2);
        ssz        = grp_size(src_l2);
        misaligned = !grp_aligned(src, ssz);
        clash      = (src_l2 < 4'sd0) ? clash_strict(rd, dsz, src, ssz)
                                      : clash_relaxed(rd, dsz, src, ssz);
        bad        = used && (misaligned || (ovl_chk && clash));
    end
endmodule

// File: rtl/vwid_legal_core.sv
module vwid_legal_core
    import vwid_pkg::*;
(
    input  ridx_t      rd,
    input  ridx_t      rs1,
    input  ridx_t      rs2,
    input  logic [2:0] lmul,
    input  logic [1:0] sew,
    input  logic [1:0] elen,
    input  logic [2:0] op_class,
    input  logic       rs1_is_vec,
    input  logic       unmasked,
    output logic       illegal
);
    geom_t geom;
    l2_t   base;
    logic  reserved;
    logic  limit_bad;
    logic  rd_bad;
    logic  mask_bad;
    logic [NUM_SRC-1:0] src_bad;

    ridx_t src_reg  [NUM_SRC];
    l2_t   src_l2   [NUM_SRC];
    logic  src_used [NUM_SRC];
    logic  src_ovl  [NUM_SRC];

    vwid_geom u_geom (
        .lmul       (lmul),
        .op_class   (op_class),
        .rs1_is_vec (rs1_is_vec),
        .geom       (geom)
    );

    always_comb begin
        src_reg[0]  = rs2;
        src_l2[0]   = geom.s2_l2;
        src_used[0] = 1'b1;
        src_ovl[0]  = geom.s2_ovl_chk;
        src_reg[1]  = rs1;
        src_l2[1]   = geom.s1_l2;
        src_used[1] = geom.s1_used;
        src_ovl[1]  = 1'b1;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        vwid_src_chk u_chk (
            .rd      (rd),
            .dst_l2  (geom.dst_l2),
            .src     (src_reg[i]),
            .src_l2  (src_l2[i]),
            .used    (src_used[i]),
            .ovl_chk (src_ovl[i]),
            .bad     (src_bad[i])
        );
    end

    always_comb begin
        base      = {lmul[2], lmul};
        reserved  = (lmul == 3'b100) || (op_class > EXT_D8);
        limit_bad = 1'b0;
        case (op_class)
            WID_DS, WID_DD:
                limit_bad = (base > 4'sd2) || (({1'b0, sew} + 3'd1) > {1'b0, elen});
            WID_QS:
                limit_bad = (base > 4'sd1) || (({1'b0, sew} + 3'd2) > {1'b0, elen});
            EXT_D2, EXT_D4, EXT_D8:
                limit_bad = (sew < geom.ext_k);
            default: limit_bad = 1'b0;
        endcase
        rd_bad   = !grp_aligned(rd, grp_size(geom.dst_l2));
        mask_bad = !unmasked && (rd == '0);
        illegal  = reserved || limit_bad || rd_bad || mask_bad || (|src_bad);
    end
endmodule

// File: rtl/vwid_legal_chk.sv
module vwid_legal_chk
    import vwid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [4:0] rd,
    input  logic [4:0] rs1,
    input  logic [4:0] rs2,
    input  logic [2:0] lmul,
    input  logic [1:0] sew,
    input  logic [1:0] elen,
    input  logic [2:0] op_class,
    input  logic       rs1_is_vec,
    input  logic       unmasked,
    output logic       res_valid,
    output logic       illegal
);
    logic verdict;

    vwid_legal_core u_core (
        .rd         (rd),
        .rs1        (rs1),
        .rs2        (rs2),
        .lmul       (lmul),
        .sew        (sew),
        .elen       (elen),
        .op_class   (op_class),
        .rs1_is_vec (rs1_is_vec),
        .unmasked   (unmasked),
        .illegal    (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) illegal <= verdict;
        end
    end
endmodule

// File: rtl/vwid_legal_sva.sv
module vwid_legal_sva (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [4:0] rd,
    input logic [2:0] lmul,
    input logic [2:0] op_class,
    input logic       unmasked,
    input logic       res_valid,
    input logic       illegal
);
    // R1
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    // R1
    idle_holds_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(illegal)));

    // R2
    reserved_lmul_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lmul == 3'b100) |=> illegal);

    // R3
    reserved_class_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class > 3'd5) |=> illegal);

    // R4
    masked_rd0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !unmasked && rd == 5'd0) |=> illegal);

    // R9
    quad_lmul_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_class == 3'd1 && !lmul[2] && lmul > 3'd1) |=> illegal);
endmodule

bind vwid_legal_chk vwid_legal_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .rd        (rd),
    .lmul      (lmul),
    .op_class  (op_class),
    .unmasked  (unmasked),
    .res_valid (res_valid),
    .illegal   (illegal)
);

// File: tb/sim_vwid_legal_chk.sv
`timescale 1ns/1ps
module sim_vwid_legal_chk;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [4:0] rd = '0, rs1 = '0, rs2 = '0;
    logic [2:0] lmul = '0, op_class = '0;
    logic [1:0] sew = '0, elen = '0;
    logic       rs1_is_vec = 1'b0, unmasked = 1'b1;
    logic       res_valid, illegal;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vwid_legal_chk u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .rd(rd), .rs1(rs1), .rs2(rs2), .lmul(lmul), .sew(sew), .elen(elen),
        .op_class(op_class), .rs1_is_vec(rs1_is_vec), .unmasked(unmasked),
        .res_valid(res_valid), .illegal(illegal)
    );

    // Reference: register sets as bit masks
    function automatic logic [127:0] regset(int st, int n);
        int m = (n == 0) ? 1 : n;
        return ((128'd1 << m) - 128'd1) << st;
    endfunction

    function automatic int gsize(int l2);
        return (l2 < 0) ? 0 : (1 << l2);
    endfunction

    function automatic bit is_mult(int r, int n);
        return (n == 0) || ((r % n) == 0);
    endfunction

    function automatic bit conflicts(int d, int dn, int s, int sn);
        int  sm = (sn == 0) ? 1 : sn;
        bit  share = |(regset(d, dn) & regset(s, sn));
        bit  top   = (d < s) && !(|(regset(d, dn) & regset(s + sm, sn)));
        if (sn == 0) return share;       // strict
        return share && !top;            // relaxed
    endfunction

    function automatic bit ref_ill(int op, int lm, int d, int r1, int r2,
                                   int sw, int el, bit r1v, bit um);
        int dl, sl2, sl1, k;
        bit bad = 1'b0;
        if (lm == -4 || op > 5) return 1'b1;
        if (!um && d == 0) bad = 1'b1;
        if (op <= 2) begin
            dl  = (op == 1) ? lm + 2 : lm + 1;
            sl2 = (op == 2) ? lm + 1 : lm;
            sl1 = lm;
            if (op == 1) begin
                if (lm > 1 || sw + 2 > el) bad = 1'b1;
            end else begin
                if (lm > 2 || sw + 1 > el) bad = 1'b1;
            end
            if (!is_mult(d, gsize(dl))) bad = 1'b1;
            if (!is_mult(r2, gsize(sl2))) bad = 1'b1;
            if (op != 2 && conflicts(d, gsize(dl), r2, gsize(sl2))) bad = 1'b1;
            if (r1v) begin
                if (!is_mult(r1, gsize(sl1))) bad = 1'b1;
                if (conflicts(d, gsize(dl), r1, gsize(sl1))) bad = 1'b1;
            end
        end else begin
            k   = op - 2;
            dl  = lm;
            sl2 = lm - k;
            if (sw < k) bad = 1'b1;
            if (!is_mult(d, gsize(dl))) bad = 1'b1;
            if (!is_mult(r2, gsize(sl2))) bad = 1'b1;
            if (conflicts(d, gsize(dl), r2, gsize(sl2))) bad = 1'b1;
        end
        return bad;
    endfunction

    // Drive at a falling edge, read at the next falling edge
    task automatic step(int op, int lm, int d, int r1, int r2, int sw, int el,
                        bit r1v, bit um, bit exp_ill, string tag);
        op_class   = 3'(op);
        lmul       = 3'(lm);
        rd         = 5'(d);
        rs1        = 5'(r1);
        rs2        = 5'(r2);
        sew        = 2'(sw);
        elen       = 2'(el);
        rs1_is_vec = r1v;
        unmasked   = um;
        in_valid   = 1'b1;
        @(negedge clk);
        n_chk++;
        if (res_valid !== 1'b1 || illegal !== exp_ill) begin
            n_err++;
            $display("FAIL %s: op=%0d lmul=%0d rd=%0d rs1=%0d rs2=%0d sew=%0d elen=%0d v1=%0b um=%0b actual valid=%b illegal=%b expected valid=1 illegal=%b",
                     tag, op, lm, d, r1, r2, sw, el, r1v, um, res_valid, illegal, exp_ill);
        end
    endtask

    task automatic sweep(int op, int lm, int d, int r1, int r2, int sw, int el,
                         bit r1v, bit um, string tag);
        step(op, lm, d, r1, r2, sw, el, r1v, um,
             ref_ill(op, lm, d, r1, r2, sw, el, r1v, um), tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        bit held;
        repeat (3) @(negedge clk);
        n_chk++;
        if (res_valid !== 1'b0 || illegal !== 1'b0) begin
            n_err++;
            $display("FAIL R1 reset: actual valid=%b illegal=%b expected 0 0", res_valid, illegal);
        end
        rst = 1'b0;
        @(negedge clk);

        // Directed cases
        step(0,  0, 0, 0, 1, 0, 3, 0, 1, 0, "R7 top slice allowed");
        step(0,  0, 0, 0, 0, 0, 3, 0, 1, 1, "R7 bottom slice clash");
        step(1,  1, 0, 0, 6, 0, 3, 0, 1, 0, "R9 R7 quad top slice");
        step(1,  1, 0, 0, 4, 0, 3, 0, 1, 1, "R9 R7 quad middle clash");
        step(1,  2, 0, 0, 16, 0, 3, 0, 1, 1, "R9 quad lmul limit");
        step(1,  0, 0, 0, 4, 2, 3, 0, 1, 1, "R9 quad width limit");
        step(0, -1, 2, 0, 3, 0, 3, 0, 1, 0, "R6 strict disjoint");
        step(0, -1, 2, 0, 2, 0, 3, 0, 1, 1, "R6 strict clash");
        step(0,  3, 0, 0, 16, 0, 3, 0, 1, 1, "R8 lmul limit");
        step(0,  0, 0, 0, 4, 3, 3, 0, 1, 1, "R8 width limit");
        step(2,  0, 0, 0, 0, 0, 3, 0, 1, 0, "R10 rs2 not overlap checked");
        step(2,  0, 0, 0, 1, 0, 3, 0, 1, 1, "R10 rs2 misaligned");
        step(2,  0, 0, 0, 2, 0, 3, 1, 1, 1, "R11 rs1 vector clash");
        step(2,  0, 0, 1, 2, 0, 3, 1, 1, 0, "R11 rs1 top slice");
        step(2,  0, 0, 0, 2, 0, 3, 0, 1, 0, "R11 rs1 scalar ignored");
        step(4,  1, 0, 0, 1, 2, 3, 0, 1, 1, "R12 R6 ext4 strict clash");
        step(4,  1, 0, 0, 2, 2, 3, 0, 1, 0, "R12 ext4 legal");
        step(4,  1, 0, 0, 2, 1, 3, 0, 1, 1, "R12 source width too small");
        step(5,  3, 0, 0, 7, 3, 3, 0, 1, 0, "R12 R7 ext8 top slice");
        step(5,  3, 0, 0, 6, 3, 3, 0, 1, 1, "R12 R7 ext8 clash");
        step(3,  0, 0, 0, 1, 1, 3, 1, 1, 0, "R12 rs1 ignored");
        step(0,  0, 0, 0, 4, 0, 3, 0, 0, 1, "R4 masked rd0");
        step(0,  0, 2, 0, 4, 0, 3, 0, 0, 0, "R4 masked rd2");
        step(0, -4, 8, 0, 4, 0, 3, 0, 1, 1, "R2 reserved lmul");
        step(6,  0, 8, 0, 4, 0, 3, 0, 1, 1, "R3 class 6");
        step(7,  0, 8, 0, 4, 0, 3, 0, 1, 1, "R3 class 7");
        step(0,  1, 2, 0, 8, 0, 3, 0, 1, 1, "R5 rd misaligned");
        step(0, -2, 3, 0, 5, 0, 3, 0, 1, 0, "R5 fractional aligned");

        // Hold: drop strobe, change fields, verdict must stay
        step(0, 0, 0, 0, 0, 0, 3, 0, 1, 1, "R1 before hold");
        in_valid = 1'b0;
        op_class = 3'd0; lmul = 3'd0; rd = 5'd2; rs2 = 5'd4;
        @(negedge clk);
        @(negedge clk);
        held = (res_valid === 1'b0) && (illegal === 1'b1);
        n_chk++;
        if (!held) begin
            n_err++;
            $display("FAIL R1 hold: actual valid=%b illegal=%b expected valid=0 illegal=1", res_valid, illegal);
        end

        // Sweep: class x grouping x destination x source 2
        for (int op = 0; op < 8; op++)
            for (int lm = -4; lm < 4; lm++)
                for (int d = 0; d < 32; d++)
                    for (int r2 = 0; r2 < 32; r2++)
                        sweep(op, lm, d, 0, r2, 0, 3, 0, 1, "R2 R3 R5 R6 R7 R10 R12 sweep");

        // Sweep: source 1 as vector, mask toggling
        for (int op = 0; op < 3; op++)
            for (int lm = -4; lm < 4; lm++)
                for (int d = 0; d < 32; d++)
                    for (int r1 = 0; r1 < 32; r1++)
                        sweep(op, lm, d, r1, 16, 0, 3, 1, r1[0], "R4 R11 sweep");

        // Sweep: widths
        for (int op = 0; op < 8; op++)
            for (int lm = -4; lm < 4; lm++)
                for (int sw = 0; sw < 4; sw++)
                    for (int el = 0; el < 4; el++) begin
                        sweep(op, lm, 8, 0, 12, sw, el, 0, 1, "R8 R9 R12 width sweep");
                        sweep(op, lm, 8, 0, 9,  sw, el, 0, 1, "R8 R9 R12 width sweep");
                    end

        in_valid = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule